// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block models a small synchronous static RAM whose bus never needs an idle cycle when it changes direction. Reads and writes can alternate on consecutive clocks. The data bus carries one beat per clock because write data arrives later than its address. In the pipelined mode it arrives two clocks later, and in the flow-through mode one clock later. That is the same distance by which read data trails its address. A static mode pin picks the variant.

Every cycle is either an address load or a burst advance. An address load starts an access only when three chip enables are all active. A burst advance steps the low two address bits through four beats, in linear or interleaved order. Each 9-bit byte lane of the word has its own write enable. An asynchronous output enable can switch the data outputs off at any moment. An asynchronous sleep input blocks every access while it is high, and the stored contents are kept.

Top module: `lw_sram_core`

## Requirements
- R1: An access begins at a rising edge only when `adv`=0, `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Any other enable pattern with `adv`=0 is a deselect: nothing is written and no read data is driven.
- R2: Pipelined mode (`flow_mode`=0). A read whose address is taken at edge k drives `dq_oe`=1 and the data on `dq_o` from just after edge k+1 until edge k+2.
- R3: Pipelined mode. The write data for an address taken at edge k is sampled from `wdata` at edge k+2.
- R4: Flow-through mode (`flow_mode`=1). Read data for an address taken at edge k is driven from just after edge k until edge k+1. Write data for an address taken at edge k is sampled at edge k+1.
- R5: With `adv`=1, a burst continues in the direction set by its load. The upper address bits stay unchanged. For beat n (n=1..3) the low two bits are (start+n) mod 4 when `lin_order`=1, and start XOR n when `lin_order`=0.
- R6: `adv`=1 after a deselect, a sleep cycle or reset is itself a deselect. A new address load always restarts the beat count at 0.
- R7: `bwe_n[i]`=0 on a write beat's address clock writes bits [9i+8:9i] of the word. Lanes with `bwe_n[i]`=1 keep their old contents.
- R8: Reads and writes can alternate on consecutive clocks with no idle cycle. A pipelined read of an address whose write is still pending returns the new write data in the enabled lanes and the stored data in the other lanes.
- R9: `oe_n`=1 drives `dq_oe` to 0 and `dq_o` to 0 at once, without a clock. It does not disturb the data in flight, which reappears as soon as `oe_n` returns to 0.
- R10: While `sleep`=1, `dq_oe` is 0, every cycle is a deselect and no write is committed. Stored contents are kept.
- R11: After reset `dq_oe` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_mode | input | 1 | Static: 1 flow-through, 0 pipelined |
| lin_order | input | 1 | Static: 1 linear burst, 0 interleaved |
| sleep | input | 1 | Asynchronous power-down, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 advance burst, 0 load address |
| we_n | input | 1 | On a load, 0 write, 1 read |
| bwe_n | input | BYTES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTES*BYTE_W | Late write data |
| dq_o | output | BYTES*BYTE_W | Read data, 0 while not driven |
| dq_oe | output | 1 | Output drive enable, models the tristate control |

## Verification
The hardest case to reach from the ports is a pipelined read of an address that still has a pending write. In that case the memory commit and the output-register capture fall on the same edge, and only some byte lanes are enabled. The bench issues a partial-lane write, follows it on the very next clock with a read of the same address, and supplies the write data on the clock after that. It then expects a per-lane blend of old and new data. A fully busy flow-through sequence alternates writes and reads on every clock to show that the bus never idles.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  localparam int BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits of a burst beat: linear adds, interleaved XORs.
  function automatic beat_t burst_lo(input beat_t start, input beat_t beat, input logic lin);
    beat_t r;
    if (lin) r = start + beat;
    else     r = start ^ beat;
    return r;
  endfunction

endpackage

// File: rtl/lw_burst_ctrl.sv
module lw_burst_ctrl
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              lin_order,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [BYTES-1:0]  bwe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_valid,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BYTES-1:0]  cmd_be
);

  logic              live_q;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  beat_t             beat_q;
  beat_t             beat_nx;
  logic              sel_all;
  logic              cmd_load;
  logic              cmd_cont;
  logic [ADDR_W-1:0] step_addr;

  assign sel_all  = !ce_a_n && ce_b && !ce_c_n;
  assign cmd_load = !sleep && !adv && sel_all;
  assign cmd_cont = !sleep && adv && live_q;
  assign beat_nx  = beat_q + beat_t'(1);

  assign step_addr = {base_q[ADDR_W-1:BEAT_W], burst_lo(base_q[BEAT_W-1:0], beat_nx, lin_order)};

  assign cmd_valid = cmd_load || cmd_cont;
  assign cmd_wr    = cmd_load ? !we_n : wr_q;
  assign cmd_addr  = cmd_load ? addr : step_addr;
  assign cmd_be    = (cmd_valid && cmd_wr) ? ~bwe_n : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else begin
      live_q <= cmd_valid;
      if (cmd_load) begin
        base_q <= addr;
        beat_q <= '0;
        wr_q   <= !we_n;
      end else if (cmd_cont) begin
        beat_q <= beat_nx;
      end
    end
  end

  // R5: a linear burst beat is one above the previous beat, modulo 4
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cont && lin_order) |-> (cmd_addr[BEAT_W-1:0] == beat_t'($past(cmd_addr[BEAT_W-1:0]) + beat_t'(1))));

  // R5: the first interleaved beat after a load flips bit 0
  a_r5_interleave_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cont && !lin_order && $past(cmd_load)) |-> (cmd_addr[BEAT_W-1:0] == ($past(cmd_addr[BEAT_W-1:0]) ^ beat_t'(1))));

  // R6: an advance counts only after an accepted cycle
  a_r6_adv_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cmd_valid) |-> $past(cmd_valid));

endmodule

// File: rtl/lw_late_pipe.sv
module lw_late_pipe #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_mode,
  input  logic              sleep,
  input  logic              cmd_valid,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BYTES-1:0]  cmd_be,
  output logic              s1_valid,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              s2_valid,
  output logic              s2_wr,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [BYTES-1:0]  s2_be,
  output logic              cm_en,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [BYTES-1:0]  cm_be
);

  logic [BYTES-1:0] s1_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_be    <= '0;
      s2_valid <= 1'b0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_be    <= '0;
    end else begin
      s1_valid <= cmd_valid;
      s1_wr    <= cmd_wr;
      s1_addr  <= cmd_addr;
      s1_be    <= cmd_be;
      s2_valid <= s1_valid;
      s2_wr    <= s1_wr;
      s2_addr  <= s1_addr;
      s2_be    <= s1_be;
    end
  end

  // Commit stage: one clock late in flow-through, two clocks late in pipelined mode.
  assign cm_en   = !sleep && (flow_mode ? (s1_valid && s1_wr) : (s2_valid && s2_wr));
  assign cm_addr = flow_mode ? s1_addr : s2_addr;
  assign cm_be   = flow_mode ? s1_be   : s2_be;

  // R4: flow-through writes commit one clock after the address
  a_r4_single_late: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && cm_en) |-> $past(cmd_valid && cmd_wr));

  // R3: pipelined writes commit two clocks after the address
  a_r3_double_late: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && cm_en) |-> $past(cmd_valid && cmd_wr, 2));

endmodule

// File: rtl/lw_byte_lanes.sv
module lw_byte_lanes #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [BYTES-1:0]        wbe,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [BYTES*BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[g]) lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
  end

endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_mode,
  input  logic                    lin_order,
  input  logic                    sleep,
  input  logic                    oe_n,
  input  logic                    ce_a_n,
  input  logic                    ce_b,
  input  logic                    ce_c_n,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic [BYTES-1:0]        bwe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  output logic [BYTES*BYTE_W-1:0] dq_o,
  output logic                    dq_oe
);

  localparam int W = BYTES * BYTE_W;

  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old_w,
                                               input logic [W-1:0] new_w,
                                               input logic [BYTES-1:0] be);
    logic [W-1:0] r;
    r = old_w;
    for (int b = 0; b < BYTES; b++) begin
      if (be[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction

  logic              cmd_valid, cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BYTES-1:0]  cmd_be;
  logic              s1_valid, s1_wr, s2_valid, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [BYTES-1:0]  s2_be;
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [BYTES-1:0]  cm_be;
  logic [W-1:0]      mem_rdata;
  logic              fwd_hit;
  logic [W-1:0]      pl_next;
  logic              out_v;
  logic [W-1:0]      out_q;
  logic              ft_v;
  logic              s1_read;

  lw_burst_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_burst (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .lin_order(lin_order),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .adv(adv), .we_n(we_n),
    .bwe_n(bwe_n), .addr(addr),
    .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_be(cmd_be)
  );

  lw_late_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .sleep(sleep),
    .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_be(cmd_be),
    .s1_valid(s1_valid), .s1_wr(s1_wr), .s1_addr(s1_addr),
    .s2_valid(s2_valid), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_be(s2_be),
    .cm_en(cm_en), .cm_addr(cm_addr), .cm_be(cm_be)
  );

  lw_byte_lanes #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_lanes (
    .clk(clk), .we(cm_en), .waddr(cm_addr), .wbe(cm_be), .wdata(wdata),
    .raddr(s1_addr), .rdata(mem_rdata)
  );

  assign s1_read = s1_valid && !s1_wr;

  // Pipelined capture shares an edge with the pending write's commit: forward it.
  assign fwd_hit = !sleep && s2_valid && s2_wr && (s2_addr == s1_addr);
  assign pl_next = fwd_hit ? lane_merge(mem_rdata, wdata, s2_be) : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_q <= '0;
    end else begin
      out_v <= !flow_mode && s1_read;
      if (s1_read) out_q <= pl_next;
    end
  end

  assign ft_v  = flow_mode && s1_read;
  assign dq_oe = !oe_n && !sleep && (flow_mode ? ft_v : out_v);
  assign dq_o  = dq_oe ? (flow_mode ? mem_rdata : out_q) : '0;

  // R1: a deselect cycle never enters the access pipeline
  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !(!ce_a_n && ce_b && !ce_c_n)) |=> !s1_valid);

  // R2: a pipelined read accepted last cycle is driven unless suppressed
  a_r2_pipe_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && !oe_n && !sleep && $past(s1_valid && !s1_wr)) |-> dq_oe);

endmodule

// File: tb/lw_sram_core_tb_top.sv
module lw_sram_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] SEL = 3'b010;  // {ce_a_n, ce_b, ce_c_n}

  logic        clk = 1'b0;
  logic        rst_n, flow_mode, lin_order, sleep, oe_n;
  logic        ce_a_n, ce_b, ce_c_n, adv, we_n;
  logic [1:0]  bwe_n;
  logic [5:0]  addr;
  logic [17:0] wdata;
  logic [17:0] dq_o;
  logic        dq_oe;

  int n_run  = 0;
  int n_fail = 0;
  logic [17:0] mdl [64];

  // {flow, addr[6], data[18], bwe_n[2]}
  localparam logic [26:0] TBL [8] = '{
    {1'b0, 6'd3, 18'h2A5C3, 2'b00},
    {1'b1, 6'd4, 18'h1F00F, 2'b00},
    {1'b0, 6'd3, 18'h3FFFF, 2'b01},
    {1'b1, 6'd4, 18'h00000, 2'b10},
    {1'b0, 6'd7, 18'h12345, 2'b00},
    {1'b1, 6'd7, 18'h0ABCD, 2'b11},
    {1'b1, 6'd3, 18'h15555, 2'b10},
    {1'b0, 6'd4, 18'h2AAAA, 2'b01}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  lw_sram_core dut_i (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .lin_order(lin_order),
    .sleep(sleep), .oe_n(oe_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .adv(adv), .we_n(we_n), .bwe_n(bwe_n), .addr(addr), .wdata(wdata),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  function automatic logic [17:0] blend(input logic [17:0] old_w, input logic [17:0] new_w,
                                        input logic [1:0] be_n);
    logic [17:0] m;
    m = {{9{~be_n[1]}}, {9{~be_n[0]}}};
    return (old_w & ~m) | (new_w & m);
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drives one cycle at a falling edge, returns at the next falling edge.
  task automatic tick(input logic [2:0] ce, input logic a_adv, input logic a_we_n,
                      input logic [1:0] a_bwe_n, input logic [5:0] a_addr, input logic [17:0] a_wd);
    {ce_a_n, ce_b, ce_c_n} = ce;
    adv = a_adv; we_n = a_we_n; bwe_n = a_bwe_n; addr = a_addr; wdata = a_wd;
    @(negedge clk);
  endtask

  task automatic nop(input logic [17:0] wd);
    tick(3'b000, 1'b0, 1'b1, 2'b11, 6'd0, wd);
  endtask

  task automatic drain();
    nop(18'h0); nop(18'h0); nop(18'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [17:0] d;
    rst_n = 1'b0; flow_mode = 1'b0; lin_order = 1'b1; sleep = 1'b0; oe_n = 1'b0;
    {ce_a_n, ce_b, ce_c_n} = 3'b000; adv = 1'b0; we_n = 1'b1; bwe_n = 2'b11;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 reset dq_oe", {17'd0, dq_oe}, 18'd0);

    // Table walk: write then read, in the mode of each entry (R2 R3 R4 R7)
    for (int i = 0; i < 8; i++) begin
      logic        f;
      logic [5:0]  a;
      logic [1:0]  b;
      f = TBL[i][26]; a = TBL[i][25:20]; d = TBL[i][19:2]; b = TBL[i][1:0];
      flow_mode = f;
      if (i < 2) mdl[a] = d;                        // first lane writes are full
      else mdl[a] = blend(mdl[a], d, b);
      if (!f) begin
        tick(SEL, 1'b0, 1'b0, b, a, 18'h0);
        nop(18'h0);
        nop(d);                                     // R3 data two edges late
        tick(SEL, 1'b0, 1'b1, 2'b11, a, 18'h0);
        nop(18'h0);
        chk("R2 pipelined read oe", {17'd0, dq_oe}, 18'd1);
        chk("R7 pipelined lane write", dq_o, mdl[a]);
      end else begin
        tick(SEL, 1'b0, 1'b0, b, a, 18'h0);
        nop(d);                                     // R4 data one edge late
        tick(SEL, 1'b0, 1'b1, 2'b11, a, 18'h0);
        chk("R4 flow read oe", {17'd0, dq_oe}, 18'd1);
        chk("R7 flow lane write", dq_o, mdl[a]);
      end
      drain();
    end

    // R8: pipelined read right after a partial write of the same address
    flow_mode = 1'b0;
    d = 18'h2F0F1;
    tick(SEL, 1'b0, 1'b0, 2'b01, 6'd3, 18'h0);
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'd3, 18'h0);
    nop(d);
    mdl[3] = blend(mdl[3], d, 2'b01);
    chk("R8 forwarded partial write", dq_o, mdl[3]);
    drain();

    // R8: flow-through W R W R on every clock
    flow_mode = 1'b1;
    tick(SEL, 1'b0, 1'b0, 2'b00, 6'd10, 18'h0);
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'd3, 18'h11111);
    mdl[10] = 18'h11111;
    chk("R8 flow read between writes", dq_o, mdl[3]);
    tick(SEL, 1'b0, 1'b0, 2'b00, 6'd11, 18'h0);
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'd10, 18'h22222);
    mdl[11] = 18'h22222;
    chk("R8 flow read of prior write", dq_o, mdl[10]);
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'd11, 18'h0);
    chk("R8 flow read back to back", dq_o, mdl[11]);
    drain();

    // R5: pipelined linear write burst from 0x22: 22,23,20,21
    flow_mode = 1'b0; lin_order = 1'b1;
    tick(SEL, 1'b0, 1'b0, 2'b00, 6'h22, 18'h0);
    tick(3'b000, 1'b1, 1'b1, 2'b00, 6'h0, 18'h0);
    tick(3'b000, 1'b1, 1'b1, 2'b00, 6'h0, 18'h0A0A0);
    tick(3'b000, 1'b1, 1'b1, 2'b00, 6'h0, 18'h0B0B0);
    nop(18'h0C0C0);
    nop(18'h0D0D0);
    mdl[6'h22] = 18'h0A0A0; mdl[6'h23] = 18'h0B0B0;
    mdl[6'h20] = 18'h0C0C0; mdl[6'h21] = 18'h0D0D0;
    drain();
    // R5: interleaved read burst from 0x21: 21,20,23,22
    lin_order = 1'b0;
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'h21, 18'h0);
    tick(3'b000, 1'b1, 1'b0, 2'b11, 6'h0, 18'h0);
    chk("R5 interleave beat0", dq_o, mdl[6'h21]);
    tick(3'b000, 1'b1, 1'b0, 2'b11, 6'h0, 18'h0);
    chk("R5 interleave beat1", dq_o, mdl[6'h20]);
    tick(3'b000, 1'b1, 1'b0, 2'b11, 6'h0, 18'h0);
    chk("R5 interleave beat2", dq_o, mdl[6'h23]);
    nop(18'h0);
    chk("R5 interleave beat3", dq_o, mdl[6'h22]);
    drain();

    // R6: reload mid-burst restarts the beat count (linear)
    lin_order = 1'b1;
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'h22, 18'h0);
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'h20, 18'h0);
    chk("R6 first load", dq_o, mdl[6'h22]);
    tick(3'b000, 1'b1, 1'b1, 2'b11, 6'h0, 18'h0);
    chk("R6 second load", dq_o, mdl[6'h20]);
    nop(18'h0);
    chk("R6 restarted beat", dq_o, mdl[6'h21]);
    drain();

    // R6: advance after a deselect is ignored
    tick(3'b000, 1'b1, 1'b1, 2'b11, 6'h0, 18'h0);
    nop(18'h0);
    chk("R6 advance after deselect", {17'd0, dq_oe}, 18'd0);

    // R1: partial enables deselect reads and writes
    tick(3'b110, 1'b0, 1'b1, 2'b11, 6'd7, 18'h0);
    nop(18'h0);
    chk("R1 read with ce_a_n high", {17'd0, dq_oe}, 18'd0);
    flow_mode = 1'b1;
    tick(3'b011, 1'b0, 1'b0, 2'b00, 6'd4, 18'h0);
    nop(18'h01234);
    tick(3'b000, 1'b0, 1'b1, 2'b11, 6'd4, 18'h0);
    chk("R1 read with ce_b low", {17'd0, dq_oe}, 18'd0);
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'd4, 18'h0);
    chk("R1 write with ce_c_n high dropped", dq_o, mdl[4]);
    drain();

    // R9: output enable override is asynchronous
    flow_mode = 1'b0;
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'd7, 18'h0);
    oe_n = 1'b1;
    nop(18'h0);
    chk("R9 oe_n high dq_oe", {17'd0, dq_oe}, 18'd0);
    chk("R9 oe_n high dq_o", dq_o, 18'd0);
    oe_n = 1'b0;
    #1;
    chk("R9 oe_n low restores data", dq_o, mdl[7]);
    drain();

    // R10: sleep blocks writes and reads, keeps contents
    sleep = 1'b1;
    tick(SEL, 1'b0, 1'b0, 2'b00, 6'd3, 18'h0);
    nop(18'h0);
    nop(18'h3C3C3);
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'd4, 18'h0);
    nop(18'h0);
    chk("R10 no drive in sleep", {17'd0, dq_oe}, 18'd0);
    sleep = 1'b0;
    drain();
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'd3, 18'h0);
    nop(18'h0);
    chk("R10 write in sleep ignored", dq_o, mdl[3]);
    drain();

    // R11: reset during a burst leaves no live burst
    tick(SEL, 1'b0, 1'b1, 2'b11, 6'd3, 18'h0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tick(3'b000, 1'b1, 1'b1, 2'b11, 6'h0, 18'h0);
    nop(18'h0);
    chk("R11 no burst after reset", {17'd0, dq_oe}, 18'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule